// File: doc/BRIEF.md
# Fractional-LMUL Vector Register File

This block is a vector register file of 32 architectural registers, each VLEN bits wide. It is addressed one element at a time. An operand can span a power-of-two group of consecutive registers (LMUL of 1, 2, 4 or 8), or only part of one register (LMUL of 1/2, 1/4 or 1/8). For each access, the block turns a register number, element width (SEW), LMUL code and element index into one physical register and one group of byte lanes. The write port commits one element per clock under the tail-undisturbed rule. The read port is combinational and uses the same address mapping.

A build-time parameter selects where a fractional register sits inside its base register. With `FRAC_TOP = 0` it sits in the lowest bytes. With `FRAC_TOP = 1` it is aligned to the top of the register. The top layout lets a full-width write with a short vector length leave fractional data in the tail of the same register untouched. A mask mode addresses a register one bit per element, whatever the LMUL.

Top module: `vrf_frac`

## Requirements
- R1: An active-low synchronous reset clears every register, so every element afterwards reads as zero.
- R2: With LMUL of 1 or more (lmul code 000=1, 001=2, 010=4, 011=8), element i of a group named by register n starts at byte i×SEW/8, counted across registers n, n+1, ... in ascending order. Bytes within an element are little-endian. The SEW code is 0=8, 1=16, 2=32, 3=64 bits.
- R3: A group access with LMUL above 1 whose register number is not a multiple of LMUL raises the error output, and a write of that kind changes no state.
- R4: With FRAC_TOP=0, a fractional register (lmul code 111=1/2, 110=1/4, 101=1/8) occupies the lowest VLEN×LMUL bits of the base register with the same number, with bytes in ascending order.
- R5: With FRAC_TOP=1, a fractional register starts at byte VLEN/8 − VLEN×LMUL/8 of its base register (1/2, 3/4 or 7/8 of the way up) and runs to the top, with bytes in ascending order.
- R6: A write whose index is at or above vl, or below vstart, leaves every register unchanged and raises no error.
- R7: With FRAC_TOP=1 and LMUL=1, writes limited to vl ≤ VLMAX/2 leave a 1/2 fractional register intact, and writes limited to vl ≤ 7/8·VLMAX leave a 1/8 fractional register intact. With FRAC_TOP=0 the same writes overwrite the fractional data.
- R8: An element index at or above VLMAX = LMUL×VLEN/SEW raises the error output, and a write of that kind changes no state.
- R9: The reserved lmul code 100, SEW above ELEN, and SEW above VLEN×LMUL are all illegal. They raise the error output and a write changes nothing.
- R10: In mask mode, element i is bit i of the named base register. SEW and LMUL are ignored, an index of VLEN or more is an error, and write data bit 0 is stored.
- R11: The read port applies the same mapping and legality rules as the write port. It returns the element zero-extended on rd_data combinationally, and raises rd_err for an illegal or out-of-range access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request this cycle |
| wr_mask_mode | input | 1 | Write addresses one mask bit |
| wr_reg | input | 5 | Write register number (group base) |
| wr_sew | input | 2 | Write element width code |
| wr_lmul | input | 3 | Write LMUL code |
| wr_idx | input | IDX_W | Write element index |
| wr_vl | input | IDX_W | Vector length for the write |
| wr_vstart | input | IDX_W | First element index allowed to be written |
| wr_data | input | ELEN | Write element, low SEW bits used |
| wr_err | output | 1 | Write request is illegal or out of range |
| rd_mask_mode | input | 1 | Read addresses one mask bit |
| rd_reg | input | 5 | Read register number |
| rd_sew | input | 2 | Read element width code |
| rd_lmul | input | 3 | Read LMUL code |
| rd_idx | input | IDX_W | Read element index |
| rd_data | output | ELEN | Read element, zero-extended |
| rd_err | output | 1 | Read request is illegal or out of range |

## Verification
The assertions assume that write-side inputs are stable across each rising edge and are driven to known values from the start of reset. They also assume wr_vl and wr_vstart are given in the same element units as wr_idx. The stimulus changes inputs only just after a rising edge, holds wr_en for exactly one edge per write, and keeps every register number within the 32 registers. Illegal codes, misaligned groups, indexes beyond VLMAX, and tail or prestart indexes appear only as single deliberate requests, each followed by a read that shows the file was left alone.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  // lmul codes: 000..011 give 1,2,4,8 registers; 101,110,111 give 1/8,1/4,1/2
  localparam logic [2:0] LMUL_RSV = 3'b100;

  function automatic int unsigned sew_bytes(input logic [1:0] s);
    return 32'd1 << s;
  endfunction

  // log2 of the divide factor of a fractional code
  function automatic int unsigned frac_shift(input logic [2:0] l);
    return 32'd4 - {30'd0, l[1:0]};
  endfunction

  // bytes covered by one operand of the given LMUL
  function automatic int unsigned group_bytes(input logic [2:0] l, input int unsigned vlenb);
    if (l[2]) return vlenb >> frac_shift(l);
    return vlenb << l[1:0];
  endfunction

  function automatic logic cfg_legal(input logic [2:0] l, input logic [1:0] s,
                                     input int unsigned rn, input int unsigned elenb,
                                     input int unsigned vlenb);
    logic ok;
    ok = (l != LMUL_RSV);
    ok = ok && (sew_bytes(s) <= elenb);
    ok = ok && (sew_bytes(s) <= group_bytes(l, vlenb));
    ok = ok && (l[2] || ((rn & ((32'd1 << l[1:0]) - 32'd1)) == 32'd0));
    return ok;
  endfunction

endpackage

// File: rtl/vrf_elem_map.sv
module vrf_elem_map
  import vrf_pkg::*;
#(
  parameter int VLEN     = 128,
  parameter int ELEN     = 64,
  parameter int NREG     = 32,
  parameter int IDX_W    = 8,
  parameter int FRAC_TOP = 1,
  localparam int RW = $clog2(NREG),
  localparam int SW = $clog2(VLEN),
  localparam int FW = $clog2(ELEN) + 1
) (
  input  logic             mask_mode,
  input  logic [RW-1:0]    rnum,
  input  logic [1:0]       sew,
  input  logic [2:0]       lmul,
  input  logic [IDX_W-1:0] idx,
  output logic             legal,
  output logic             in_range,
  output logic [RW-1:0]    phys,
  output logic [SW-1:0]    shift,
  output logic [FW-1:0]    field_w
);
  localparam int unsigned VLENB = VLEN / 8;
  localparam int unsigned ELENB = ELEN / 8;

  logic [31:0] gb, eb, vmax, abs_off, sub_base, row_off, reg_step, phys_w, shift_w, fw_w;

  always_comb begin
    gb       = group_bytes(lmul, VLENB);
    eb       = sew_bytes(sew);
    vmax     = gb / eb;
    abs_off  = 32'(idx) * eb;
    sub_base = (FRAC_TOP != 0) ? (VLENB - gb) : 32'd0;
    reg_step = 32'd0;
    row_off  = 32'd0;
    if (mask_mode) begin
      legal    = 1'b1;
      in_range = 32'(idx) < VLEN;
      shift_w  = 32'(idx);
      fw_w     = 32'd1;
    end else begin
      legal    = cfg_legal(lmul, sew, 32'(rnum), ELENB, VLENB);
      in_range = 32'(idx) < vmax;
      if (lmul[2]) begin
        row_off = sub_base + abs_off;
      end else begin
        reg_step = abs_off / VLENB;
        row_off  = abs_off % VLENB;
      end
      shift_w = row_off * 32'd8;
      fw_w    = eb * 32'd8;
    end
    phys_w  = 32'(rnum) + reg_step;
    phys    = phys_w[RW-1:0];
    shift   = shift_w[SW-1:0];
    field_w = fw_w[FW-1:0];
  end

endmodule

// File: rtl/vrf_storage.sv
module vrf_storage #(
  parameter int VLEN = 128,
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [VLEN-1:0] wdata,
  input  logic [VLEN-1:0] wmask,
  input  logic [RW-1:0]   raddr,
  output logic [VLEN-1:0] rrow
);
  logic [NREG-1:0][VLEN-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end
  end

  assign rrow = mem[raddr];

  // R6 / R8: a cycle without a commit leaves the whole file as it was
  p_idle_holds_file_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

  // R2: the selected lanes hold the written bits one cycle later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((mem[$past(waddr)] ^ $past(wdata)) & $past(wmask)) == '0));

endmodule

// File: rtl/vrf_frac.sv
module vrf_frac
  import vrf_pkg::*;
#(
  parameter int VLEN     = 128,
  parameter int ELEN     = 64,
  parameter int FRAC_TOP = 1,
  parameter int IDX_W    = $clog2(VLEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_mask_mode,
  input  logic [4:0]       wr_reg,
  input  logic [1:0]       wr_sew,
  input  logic [2:0]       wr_lmul,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] wr_vl,
  input  logic [IDX_W-1:0] wr_vstart,
  input  logic [ELEN-1:0]  wr_data,
  output logic             wr_err,
  input  logic             rd_mask_mode,
  input  logic [4:0]       rd_reg,
  input  logic [1:0]       rd_sew,
  input  logic [2:0]       rd_lmul,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ELEN-1:0]  rd_data,
  output logic             rd_err
);
  localparam int NREG = 32;
  localparam int RW   = $clog2(NREG);
  localparam int SW   = $clog2(VLEN);
  localparam int FW   = $clog2(ELEN) + 1;

  logic          wm_legal, wm_in_range, rm_legal, rm_in_range;
  logic [RW-1:0] wm_phys, rm_phys;
  logic [SW-1:0] wm_shift, rm_shift;
  logic [FW-1:0] wm_field_w, rm_field_w;

  vrf_elem_map #(.VLEN(VLEN), .ELEN(ELEN), .NREG(NREG), .IDX_W(IDX_W), .FRAC_TOP(FRAC_TOP)) u_wmap (
    .mask_mode(wr_mask_mode), .rnum(wr_reg), .sew(wr_sew), .lmul(wr_lmul), .idx(wr_idx),
    .legal(wm_legal), .in_range(wm_in_range), .phys(wm_phys), .shift(wm_shift), .field_w(wm_field_w));

  vrf_elem_map #(.VLEN(VLEN), .ELEN(ELEN), .NREG(NREG), .IDX_W(IDX_W), .FRAC_TOP(FRAC_TOP)) u_rmap (
    .mask_mode(rd_mask_mode), .rnum(rd_reg), .sew(rd_sew), .lmul(rd_lmul), .idx(rd_idx),
    .legal(rm_legal), .in_range(rm_in_range), .phys(rm_phys), .shift(rm_shift), .field_w(rm_field_w));

  // named internal events
  logic wr_fault, wr_tail_skip, wr_commit;
  assign wr_fault     = wr_en && !(wm_legal && wm_in_range);
  assign wr_tail_skip = (wr_idx >= wr_vl) || (wr_idx < wr_vstart);
  assign wr_commit    = wr_en && !wr_fault && !wr_tail_skip;
  assign wr_err       = wr_fault;

  logic [VLEN-1:0] w_ones, w_lane_mask, w_lane_data, r_ones, r_row, r_shifted;

  always_comb begin
    w_ones = '0;
    r_ones = '0;
    for (int b = 0; b < ELEN; b++) begin
      if (b < int'(wm_field_w)) w_ones[b] = 1'b1;
      if (b < int'(rm_field_w)) r_ones[b] = 1'b1;
    end
    w_lane_mask = w_ones << wm_shift;
    w_lane_data = (VLEN'(wr_data) & w_ones) << wm_shift;
    r_shifted   = (r_row >> rm_shift) & r_ones;
  end

  vrf_storage #(.VLEN(VLEN), .NREG(NREG)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(wm_phys),
    .wdata(w_lane_data), .wmask(w_lane_mask), .raddr(rm_phys), .rrow(r_row));

  assign rd_data = r_shifted[ELEN-1:0];
  assign rd_err  = !(rm_legal && rm_in_range);

  // R2: a committed group element stays inside the LMUL registers of its group
  p_group_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !wr_mask_mode && !wr_lmul[2]) |->
      ((wm_phys >= wr_reg) && (32'(wm_phys - wr_reg) < (32'd1 << wr_lmul[1:0]))));

  // R2: the written field never runs past the top of its row
  p_field_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ((32'(wm_shift) + 32'(wm_field_w)) <= VLEN));

  // R3: a misaligned group base is always reported
  p_misalign_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask_mode && !wr_lmul[2] && (wr_lmul[1:0] != 2'b00) &&
     ((32'(wr_reg) & ((32'd1 << wr_lmul[1:0]) - 32'd1)) != 32'd0)) |-> wr_err);

  // R5: top layout puts every fractional element in the upper half or above
  p_frac_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((FRAC_TOP != 0) && wr_commit && !wr_mask_mode && wr_lmul[2]) |-> (32'(wm_shift) >= (VLEN / 2)));

  // R10: a mask index beyond the register is reported
  p_mask_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask_mode && (32'(wr_idx) >= VLEN)) |-> wr_err);

  // R9: the reserved lmul code is reported
  p_rsv_lmul_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask_mode && (wr_lmul == LMUL_RSV)) |-> wr_err);

endmodule

// File: tb/vrf_frac_tb.sv
`timescale 1ns/1ps
module vrf_frac_tb_top;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int IDX_W = 8;
  localparam int VB = VLEN / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_mask_mode = 1'b0, rd_mask_mode = 1'b0;
  logic [4:0] wr_reg = '0, rd_reg = '0;
  logic [1:0] wr_sew = '0, rd_sew = '0;
  logic [2:0] wr_lmul = '0, rd_lmul = '0;
  logic [IDX_W-1:0] wr_idx = '0, wr_vl = '0, wr_vstart = '0, rd_idx = '0;
  logic [ELEN-1:0] wr_data = '0;
  logic wr_err_t, wr_err_b, rd_err_t, rd_err_b;
  logic [ELEN-1:0] rd_data_t, rd_data_b;

  always #4 clk = ~clk;

  vrf_frac #(.VLEN(VLEN), .ELEN(ELEN), .FRAC_TOP(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask_mode(wr_mask_mode), .wr_reg(wr_reg),
    .wr_sew(wr_sew), .wr_lmul(wr_lmul), .wr_idx(wr_idx), .wr_vl(wr_vl), .wr_vstart(wr_vstart),
    .wr_data(wr_data), .wr_err(wr_err_t), .rd_mask_mode(rd_mask_mode), .rd_reg(rd_reg),
    .rd_sew(rd_sew), .rd_lmul(rd_lmul), .rd_idx(rd_idx), .rd_data(rd_data_t), .rd_err(rd_err_t));

  vrf_frac #(.VLEN(VLEN), .ELEN(ELEN), .FRAC_TOP(0)) dut_lo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask_mode(wr_mask_mode), .wr_reg(wr_reg),
    .wr_sew(wr_sew), .wr_lmul(wr_lmul), .wr_idx(wr_idx), .wr_vl(wr_vl), .wr_vstart(wr_vstart),
    .wr_data(wr_data), .wr_err(wr_err_b), .rd_mask_mode(rd_mask_mode), .rd_reg(rd_reg),
    .rd_sew(rd_sew), .rd_lmul(rd_lmul), .rd_idx(rd_idx), .rd_data(rd_data_b), .rd_err(rd_err_b));

  // byte model per layout: [0] = top-aligned, [1] = bottom-placed
  logic [7:0] mdl [2][32][VB];

  typedef struct packed {
    logic            is_read;
    logic            e_err;
    logic [ELEN-1:0] e_top;
    logic [ELEN-1:0] e_bot;
  } item_t;
  item_t exp_q[$];
  string req_q[$];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic int span_bytes(int lm);
    if (lm >= 5) return VB >> (8 - lm);
    return VB << lm;
  endfunction

  function automatic bit cfg_bad(bit mm, int rn, int sw, int lm, int idx);
    int eb;
    if (mm) return idx >= VLEN;
    eb = 1 << sw;
    if (lm == 4) return 1'b1;
    if (eb > ELEN / 8 || eb > span_bytes(lm)) return 1'b1;
    if (lm < 5 && (rn % (1 << lm)) != 0) return 1'b1;
    return idx >= span_bytes(lm) / eb;
  endfunction

  function automatic int start_byte(int lay, int lm, int rn);
    return rn * VB + ((lm >= 5 && lay == 0) ? VB - span_bytes(lm) : 0);
  endfunction

  function automatic logic [ELEN-1:0] model_val(int lay, bit mm, int rn, int sw, int lm, int idx);
    logic [ELEN-1:0] v;
    int a;
    v = '0;
    if (mm) begin
      v[0] = mdl[lay][rn][idx / 8][idx % 8];
    end else begin
      for (int b = 0; b < (1 << sw); b++) begin
        a = start_byte(lay, lm, rn) + idx * (1 << sw) + b;
        v[8*b +: 8] = mdl[lay][a / VB][a % VB];
      end
    end
    return v;
  endfunction

  task automatic clear_model();
    for (int l = 0; l < 2; l++)
      for (int r = 0; r < 32; r++)
        for (int b = 0; b < VB; b++) mdl[l][r][b] = 8'h00;
  endtask

  task automatic chk(bit ok, string req, string what, logic [ELEN-1:0] act, logic [ELEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: one write request, held for one rising edge
  task automatic wr(bit mm, int rn, int sw, int lm, int idx, int vl, int vst, logic [ELEN-1:0] d, string req);
    item_t it;
    int a;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_mask_mode = mm; wr_reg = 5'(rn); wr_sew = 2'(sw); wr_lmul = 3'(lm);
    wr_idx = IDX_W'(idx); wr_vl = IDX_W'(vl); wr_vstart = IDX_W'(vst); wr_data = d;
    it = '0;
    it.is_read = 1'b0;
    it.e_err = cfg_bad(mm, rn, sw, lm, idx);
    exp_q.push_back(it);
    req_q.push_back(req);
    if (!it.e_err && idx >= vst && idx < vl) begin
      for (int l = 0; l < 2; l++) begin
        if (mm) mdl[l][rn][idx / 8][idx % 8] = d[0];
        else
          for (int b = 0; b < (1 << sw); b++) begin
            a = start_byte(l, lm, rn) + idx * (1 << sw) + b;
            mdl[l][a / VB][a % VB] = d[8*b +: 8];
          end
      end
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // driver: one read request, compared combinationally at the next falling edge
  task automatic rd(bit mm, int rn, int sw, int lm, int idx, string req);
    item_t it;
    @(posedge clk); #1;
    rd_mask_mode = mm; rd_reg = 5'(rn); rd_sew = 2'(sw); rd_lmul = 3'(lm); rd_idx = IDX_W'(idx);
    it.is_read = 1'b1;
    it.e_err = cfg_bad(mm, rn, sw, lm, idx);
    it.e_top = it.e_err ? '0 : model_val(0, mm, rn, sw, lm, idx);
    it.e_bot = it.e_err ? '0 : model_val(1, mm, rn, sw, lm, idx);
    exp_q.push_back(it);
    req_q.push_back(req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      string rq;
      it = exp_q.pop_front();
      rq = req_q.pop_front();
      if (it.is_read) begin
        chk(rd_err_t == it.e_err, rq, "rd_err top", 64'(rd_err_t), 64'(it.e_err));
        chk(rd_err_b == it.e_err, rq, "rd_err bottom", 64'(rd_err_b), 64'(it.e_err));
        if (!it.e_err) begin
          chk(rd_data_t == it.e_top, rq, "rd_data top", rd_data_t, it.e_top);
          chk(rd_data_b == it.e_bot, rq, "rd_data bottom", rd_data_b, it.e_bot);
        end
      end else begin
        chk(wr_err_t == it.e_err, rq, "wr_err top", 64'(wr_err_t), 64'(it.e_err));
        chk(wr_err_b == it.e_err, rq, "wr_err bottom", 64'(wr_err_b), 64'(it.e_err));
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    clear_model();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(0, 0, 3, 0, 0, "R1");
    rd(0, 31, 3, 0, 1, "R1");

    // R2: LMUL=2 group at v4, SEW=32, element 5 lands in v5 bytes 4..7
    wr(0, 4, 2, 1, 5, 16, 0, 64'h0000_0000_A1B2_C3D4, "R2");
    rd(0, 5, 2, 0, 1, "R2");
    rd(0, 5, 0, 0, 4, "R2");        // little-endian low byte
    // R2: LMUL=8 group at v8, SEW=64, element 15 lands in v15 upper half
    wr(0, 8, 3, 3, 15, 16, 0, 64'h0123_4567_89AB_CDEF, "R2");
    rd(0, 15, 3, 0, 1, "R2");
    rd(0, 8, 3, 3, 15, "R11");

    // R3: misaligned LMUL=4 group at v6
    wr(0, 6, 3, 2, 0, 16, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    rd(0, 6, 3, 0, 0, "R3");
    rd(0, 6, 3, 2, 0, "R11");

    // R4 / R5: LMUL=1/2 SEW=16 element 0 of v7
    wr(0, 7, 1, 7, 0, 4, 0, 64'hBEEF, "R4");
    rd(0, 7, 1, 0, 0, "R4");
    rd(0, 7, 1, 0, 4, "R5");
    rd(0, 7, 1, 7, 0, "R11");
    // R5: LMUL=1/8 SEW=8 element 1 of v9 is the top byte in the aligned layout
    wr(0, 9, 0, 5, 1, 2, 0, 64'h5A, "R5");
    rd(0, 9, 0, 0, 15, "R5");
    rd(0, 9, 0, 0, 1, "R4");

    // R6: tail and prestart indexes leave v10 alone
    wr(0, 10, 0, 0, 12, 12, 0, 64'h77, "R6");
    rd(0, 10, 0, 0, 12, "R6");
    wr(0, 10, 0, 0, 2, 12, 3, 64'h66, "R6");
    rd(0, 10, 0, 0, 2, "R6");
    wr(0, 10, 0, 0, 3, 12, 3, 64'h55, "R6");
    rd(0, 10, 0, 0, 3, "R6");

    // R7: 1/2 sub-register survives LMUL=1 writes with vl = VLMAX/2
    wr(0, 11, 2, 7, 0, 2, 0, 64'hCAFE_F00D, "R7");
    wr(0, 11, 2, 7, 1, 2, 0, 64'h1357_9BDF, "R7");
    for (int i = 0; i < 8; i++) wr(0, 11, 0, 0, i, 8, 0, 64'(8'hC0 + i), "R7");
    rd(0, 11, 2, 7, 0, "R7");
    rd(0, 11, 2, 7, 1, "R7");
    // R7: 1/8 sub-register survives vl = 7/8 VLMAX
    wr(0, 12, 1, 5, 0, 1, 0, 64'hA55A, "R7");
    for (int i = 0; i < 14; i++) wr(0, 12, 0, 0, i, 14, 0, 64'(8'h10 + i), "R7");
    rd(0, 12, 1, 5, 0, "R7");

    // R8: index at VLMAX
    wr(0, 13, 2, 0, 4, 16, 0, 64'h1111_1111, "R8");
    rd(0, 13, 2, 0, 3, "R8");
    wr(0, 13, 2, 6, 1, 16, 0, 64'h2222_2222, "R8");
    rd(0, 13, 2, 0, 3, "R8");

    // R9: illegal combinations
    wr(0, 14, 3, 5, 0, 16, 0, 64'h3333, "R9");
    wr(0, 14, 0, 4, 0, 16, 0, 64'h44, "R9");
    rd(0, 14, 3, 0, 0, "R9");
    rd(0, 14, 0, 4, 0, "R9");

    // R10: mask bit 37 of v0, lmul ignored
    wr(1, 0, 3, 4, 37, 128, 0, 64'h1, "R10");
    rd(1, 0, 0, 4, 37, "R10");
    rd(0, 0, 0, 0, 4, "R10");
    wr(1, 0, 0, 0, 128, 200, 0, 64'h1, "R10");
    rd(1, 0, 0, 0, 127, "R10");
    rd(1, 0, 0, 0, 130, "R11");

    // R1: reset in mid-run clears written data
    do_reset();
    rd(0, 5, 2, 0, 1, "R1");
    rd(0, 11, 3, 0, 1, "R1");

    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule